// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a synchronous DRAM and walks the memory from power-on to a usable state. It holds clock enable high and drives no-operation commands for a settling period after reset. It then precharges every bank and issues a configurable number of auto-refresh commands. Next it loads the mode register and, when enabled, the extended mode register that selects which banks a later self refresh keeps alive. The block then raises a ready flag.

Every wait is given in nanoseconds and turned into a clock count by dividing by the clock period and rounding up. After ready, the controller may ask for a new extended mode word, and the sequencer issues it once the controller reports that every bank is idle. Power-up is not repeated for this.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low, and for the first N_PU cycles after it rises, the command is NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1, ba=0, addr=0), cke is 1 and ready is 0. N_PU is ceil(T_PU_NS*1000/CLK_PS).
- R2: In cycle N_PU after reset release (cycle 0 being the first cycle after release), a precharge-all is driven: ras_n=0, cas_n=1, we_n=0, with addr bit 10 high and all other addr bits and ba zero.
- R3: REFRESH_COUNT auto-refresh commands (ras_n=0, cas_n=0, we_n=1) follow. The first comes N_RP cycles after the precharge and each later one N_RC cycles after the one before.
- R4: N_RC cycles after the last refresh, a mode set (ras_n=cas_n=we_n=0) is driven with ba=00 and addr=MODE_WORD.
- R5: When EXT_EN is 1, an extended mode set with ba=10 and addr=EXT_WORD comes 2 cycles after the mode set. When EXT_EN is 0, it is skipped.
- R6: ready rises 2 cycles after the last mode set of the power-up sequence and stays high until reset.
- R7: Every cycle that carries none of the commands above drives NOP.
- R8: When ready is high, the block is idle, and upd_req and banks_idle are both high at a clock edge, the next cycle drives an extended mode set with ba=10 and addr=upd_word. upd_busy is high in that cycle and the one after it, and ready stays high.
- R9: A request is ignored when banks_idle is low, before ready, or while upd_busy is high. An ignored request produces no mode set.
- R10: Wait counts round up, so a wait of 18 ns at an 8 ns clock lasts 3 cycles and 60 ns lasts 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_req | input | 1 | Request to rewrite the extended mode word |
| upd_word | input | ADDR_W | Extended mode word for the request |
| banks_idle | input | 1 | Controller reports all banks precharged |
| ready | output | 1 | Initialization complete |
| upd_busy | output | 1 | Extended mode rewrite in progress |
| cke | output | 1 | Clock enable |
| cs_n | output | 1 | Chip select |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 1 | Column strobe |
| we_n | output | 1 | Write enable |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address bus |

## Verification
The power-up sequence is compared cycle by cycle against a table of expected commands. The run uses non-integer nanosecond-to-clock ratios, so an off-by-one in rounding or in a gap moves a command and is detected. A second instance with the extended mode set disabled shows that its ready flag comes two cycles earlier and that no extended mode set appears. The rewrite path is tried three ways: a request while banks are busy, a request held across the busy window, and a request raised before ready. Together these separate acceptance from each ignore condition.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int CLK_PS        = 7500,
  parameter int T_PU_NS       = 200000,
  parameter int T_RP_NS       = 19,
  parameter int T_RC_NS       = 60,
  parameter int REFRESH_COUNT = 2,
  parameter int ADDR_W        = 12,
  parameter logic [ADDR_W-1:0] MODE_WORD = 12'h032,
  parameter bit EXT_EN        = 1'b0,
  parameter logic [ADDR_W-1:0] EXT_WORD  = 12'h000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_req,
  input  logic [ADDR_W-1:0] upd_word,
  input  logic              banks_idle,
  output logic              ready,
  output logic              upd_busy,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr
);

  localparam int MRD   = 2;
  localparam int N_PU  = (T_PU_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int N_RP0 = (T_RP_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int N_RC0 = (T_RC_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int N_RP  = (N_RP0 < 1) ? 1 : N_RP0;
  localparam int N_RC  = (N_RC0 < 2) ? 2 : N_RC0;
  localparam int CW    = $clog2(N_PU + N_RP + N_RC + 2);
  localparam int RW    = $clog2(REFRESH_COUNT + 1);

  localparam logic [2:0] C_NOP = 3'b111;
  localparam logic [2:0] C_PRE = 3'b010;
  localparam logic [2:0] C_REF = 3'b001;
  localparam logic [2:0] C_MOD = 3'b000;

  typedef enum logic [2:0] {S_PRE, S_REF, S_MRS, S_EMRS, S_FIN, S_IDLE, S_UPD} st_t;

  st_t               st;
  logic [CW-1:0]     wait_q;
  logic [RW-1:0]     ref_q;
  logic              ready_q;
  logic [ADDR_W-1:0] upd_q;
  logic [2:0]        cmd;
  logic              slot;

  assign slot = (wait_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_PRE;
      wait_q  <= CW'(N_PU);
      ref_q   <= '0;
      ready_q <= 1'b0;
      upd_q   <= '0;
    end else if (!slot) begin
      wait_q <= wait_q - 1'b1;
    end else begin
      case (st)
        S_PRE: begin
          st     <= S_REF;
          wait_q <= CW'(N_RP - 1);
        end
        S_REF: begin
          ref_q  <= ref_q + 1'b1;
          wait_q <= CW'(N_RC - 1);
          if (ref_q == RW'(REFRESH_COUNT - 1)) st <= S_MRS;
        end
        S_MRS: begin
          st     <= EXT_EN ? S_EMRS : S_FIN;
          wait_q <= EXT_EN ? CW'(MRD - 1) : CW'(MRD - 2);
        end
        S_EMRS, S_UPD: begin
          st     <= S_FIN;
          wait_q <= CW'(MRD - 2);
        end
        S_FIN: begin
          st      <= S_IDLE;
          ready_q <= 1'b1;
        end
        S_IDLE: begin
          if (upd_req && banks_idle) begin
            st    <= S_UPD;
            upd_q <= upd_word;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd  = C_NOP;
    ba   = 2'b00;
    addr = '0;
    if (slot) begin
      case (st)
        S_PRE: begin
          cmd      = C_PRE;
          addr[10] = 1'b1;
        end
        S_REF: cmd = C_REF;
        S_MRS: begin
          cmd  = C_MOD;
          addr = MODE_WORD;
        end
        S_EMRS: begin
          cmd  = C_MOD;
          ba   = 2'b10;
          addr = EXT_WORD;
        end
        S_UPD: begin
          cmd  = C_MOD;
          ba   = 2'b10;
          addr = upd_q;
        end
        default: cmd = C_NOP;
      endcase
    end
  end

  assign {ras_n, cas_n, we_n} = cmd;
  assign cs_n     = 1'b0;
  assign cke      = 1'b1;
  assign ready    = ready_q;
  assign upd_busy = ready_q && (st == S_UPD || st == S_FIN);

  // R6
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R2
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({ras_n, cas_n, we_n} == C_PRE) |-> addr[10]);

  // R5
  modeset_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({ras_n, cas_n, we_n} == C_MOD) |=> ({ras_n, cas_n, we_n} == C_NOP));

  // R9
  upd_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !upd_busy && !banks_idle) |=> ({ras_n, cas_n, we_n} != C_MOD));

  // R3
  refresh_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({ras_n, cas_n, we_n} == C_REF) |=> ({ras_n, cas_n, we_n} == C_NOP));

endmodule

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_req = 1'b0;
  logic [11:0] upd_word = '0;
  logic banks_idle = 1'b0;
  logic ready, upd_busy, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [11:0] addr;
  logic ready2, busy2, cke2, cs2, ras2, cas2, we2;
  logic [1:0] ba2;
  logic [11:0] addr2;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  sdram_init_seq #(.CLK_PS(8000), .T_PU_NS(400), .T_RP_NS(18), .T_RC_NS(60),
    .REFRESH_COUNT(3), .MODE_WORD(12'h032), .EXT_EN(1'b1), .EXT_WORD(12'h001)) uut (
    .clk(clk), .rst_n(rst_n), .upd_req(upd_req), .upd_word(upd_word),
    .banks_idle(banks_idle), .ready(ready), .upd_busy(upd_busy), .cke(cke),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr));

  sdram_init_seq #(.CLK_PS(8000), .T_PU_NS(400), .T_RP_NS(18), .T_RC_NS(60),
    .REFRESH_COUNT(3), .MODE_WORD(12'h032), .EXT_EN(1'b0)) uut_noext (
    .clk(clk), .rst_n(rst_n), .upd_req(1'b0), .upd_word(12'h000),
    .banks_idle(1'b0), .ready(ready2), .upd_busy(busy2), .cke(cke2),
    .cs_n(cs2), .ras_n(ras2), .cas_n(cas2), .we_n(we2), .ba(ba2), .addr(addr2));

  // cycle, {ras,cas,we}, ba, addr
  localparam int NEV = 6;
  localparam int EV_CYC[NEV] = '{50, 53, 61, 69, 77, 79};
  localparam int EV_CMD[NEV] = '{2, 1, 1, 1, 0, 0};
  localparam int EV_BA [NEV] = '{0, 0, 0, 0, 0, 2};
  localparam int EV_ADR[NEV] = '{'h400, 0, 0, 0, 'h032, 'h001};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
    #1;
  endtask

  function automatic int bus();
    return {cs_n, ras_n, cas_n, we_n, ba, addr};
  endfunction

  function automatic int pack(input int c, input int b, input int a);
    return {1'b0, c[2:0], b[1:0], a[11:0]};
  endfunction

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(bus() == pack(7, 0, 0) && cke && !ready, "R1 reset", bus(), pack(7, 0, 0));
    upd_req = 1'b1;
    banks_idle = 1'b1;
    upd_word = 12'hFFF;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int c = 0; c < 96; c++) begin
      int exp_b;
      exp_b = pack(7, 0, 0);
      for (int e = 0; e < NEV; e++)
        if (EV_CYC[e] == c) exp_b = pack(EV_CMD[e], EV_BA[e], EV_ADR[e]);
      // R1 R2 R3 R4 R5 R7 R9 R10: command table, requests during init ignored
      chk(bus() == exp_b && cke, "R7 cmd table", bus(), exp_b);
      // R6 ready timing
      chk(ready == (c >= 81), "R6 ready", ready, c >= 81);
      if (c == 77) chk({ras2, cas2, we2, ba2, addr2} == {3'b000, 2'b00, 12'h032},
                       "R4 noext mode set", {ras2, cas2, we2, ba2, addr2}, 17'h0032);
      if (c == 79) chk({ras2, cas2, we2} == 3'b111 && ready2, "R5 noext skip",
                       {ready2, ras2, cas2, we2}, 4'hF);
      if (c == 78) chk(!ready2, "R6 noext early", ready2, 0);
      if (c == 79) upd_req = 1'b0;
      step();
    end

    // R9 request with banks busy
    upd_req = 1'b1;
    banks_idle = 1'b0;
    upd_word = 12'hA5A;
    step();
    chk(bus() == pack(7, 0, 0) && !upd_busy, "R9 banks busy", bus(), pack(7, 0, 0));
    banks_idle = 1'b1;
    step();
    // R8 accepted rewrite
    chk(bus() == pack(0, 2, 'hA5A), "R8 update cmd", bus(), pack(0, 2, 'hA5A));
    chk(upd_busy && ready, "R8 busy", {upd_busy, ready}, 3);
    step();
    chk(bus() == pack(7, 0, 0) && upd_busy, "R8 gap", bus(), pack(7, 0, 0));
    step();
    chk(!upd_busy && bus() == pack(7, 0, 0), "R9 held while busy", bus(), pack(7, 0, 0));
    upd_req = 1'b0;
    step();
    chk(bus() == pack(7, 0, 0) && ready, "R9 no repeat", bus(), pack(7, 0, 0));

    // R6 ready clears on reset
    rst_n = 1'b0;
    step();
    chk(!ready && bus() == pack(7, 0, 0), "R6 reset clears", ready, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule